// File: doc/BRIEF.md
# Configuration Port Bridge with Word FIFOs

This block connects a simple register bus to a 32-bit configuration port through two word FIFOs. Software fills the outbound FIFO through a data register, then issues a command that streams the stored words to the port. For readback, software programs a word count and issues a second command. The bridge then takes exactly that many words from the port into the inbound FIFO, where software collects them through another data register.

Software polls two counters to pace itself: the free space in the outbound FIFO and the fill level of the inbound FIFO. A status word combines a completion flag with four condition inputs from the port. Two control bits act at once and clear themselves: one empties both FIFOs and one restores the whole block to its reset state. The two start bits stay set while their transfer runs. Software cannot start a new transfer while one is still in progress.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset, the registers read as follows: control 0, size 0, vacancy 1024, occupancy 0, status bit 0 set. A read returns its value on `bus_rdata` in the cycle after the read strobe, and `bus_rdata` holds that value until the next read. Register addresses: 0 control, 1 status, 2 size, 3 outbound data (write only, reads 0), 4 inbound data, 5 vacancy, 6 occupancy, 7 reads 0.
- R2: Status layout: bit 0 is high when no transfer is active. Bits 1 to 4 always read 1. Bit 5 reflects `port_abort_n`, bit 6 `port_rip`, bit 7 `port_dalign` and bit 8 `port_cfgerr`. All higher bits read 0.
- R3: The outbound FIFO holds 1024 words, and vacancy reads 1024 minus the number of words stored. A write to address 3 while the FIFO is full is dropped: vacancy stays 0 and the dropped word never reaches the port.
- R4: Writing control bit 0 while idle starts an outbound transfer. While the transfer runs and words are stored, `port_wvalid` is high and `port_wdata` presents the oldest word. A word moves in every cycle in which `port_busy` is low. While `port_busy` is high, the word and the valid are held.
- R5: An outbound transfer ends in the cycle after the FIFO is seen empty. Control bit 0 then reads 0 and status bit 0 reads 1. Words written during the transfer are sent before it ends.
- R6: Writing control bit 1 while idle starts a readback of as many words as the size register holds. The size register is 12 bits wide: larger values are truncated, so the maximum is 0xFFF. It counts down once per accepted word, and the readback ends in the cycle after it reads 0. A word is accepted when `port_rvalid` and `port_rready` are both high.
- R7: The inbound FIFO holds 256 words, and occupancy reports how many are stored. `port_rready` is high only during a readback with a nonzero count and free space. It goes low while the FIFO is full and returns once software frees space.
- R8: A read of address 4 removes the oldest inbound word and returns it. A read of address 4 when the FIFO is empty has no effect on occupancy; the data it returns is unspecified.
- R9: Port condition inputs change the status read in the next read, for any combination of levels.
- R10: While a transfer is active, start bits are ignored, and writes to the size register are ignored during a readback. If bits 0 and 1 are written together while idle, only the outbound transfer starts.
- R11: Writing control bit 2 empties both FIFOs. It leaves the active transfer flags and the size count unchanged, and any start bit in the same write is still honoured.
- R12: Writing control bit 3 returns every register and both FIFOs to their reset state at the next clock edge, whatever other bits are set in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| port_wvalid | output | 1 | Outbound word valid |
| port_wdata | output | 32 | Outbound word |
| port_busy | input | 1 | Port cannot take a word this cycle |
| port_rvalid | input | 1 | Readback word valid |
| port_rdata | input | 32 | Readback word |
| port_rready | output | 1 | Bridge accepts a readback word |
| port_abort_n | input | 1 | Port abort status, active low |
| port_rip | input | 1 | Port readback-in-progress status |
| port_dalign | input | 1 | Port data-aligned status |
| port_cfgerr | input | 1 | Port configuration error status |

## Verification
The bench overfills the outbound FIFO past 1024 words and then drains it with random back-pressure. A bridge that stored or forwarded a dropped word would put an unexpected value on `port_wdata`, or a vacancy other than 0. A readback longer than the inbound depth is run so the port side must stall at 256 words. A design that ignored fullness would hold `port_rready` high and lose words. A design that failed to resume would hang with the size count stuck above zero. The bench also issues starts while busy, size writes during readback, both start bits together, a flush in the middle of a readback and a reset combined with a start. A design that let any of these through would show wrong control, size or occupancy values, which the cycle-by-cycle model compares.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_SIZE  = 3'd2;
  localparam logic [ADDR_W-1:0] A_WDATA = 3'd3;
  localparam logic [ADDR_W-1:0] A_RDATA = 3'd4;
  localparam logic [ADDR_W-1:0] A_WVAC  = 3'd5;
  localparam logic [ADDR_W-1:0] A_ROCC  = 3'd6;

  localparam int CTL_GO_WR  = 0;
  localparam int CTL_GO_RD  = 1;
  localparam int CTL_FLUSH  = 2;
  localparam int CTL_SOFT   = 3;

  localparam int STAT_W     = 9;
  localparam logic [3:0] STAT_ONES = 4'hF;
endpackage

// File: rtl/cpb_fifo.sv
module cpb_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH)); // R3

  AST_FIFO_DROP_FULL: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> count == $past(count)); // R3
endmodule

// File: rtl/cpb_xfer_engine.sv
module cpb_xfer_engine #(
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [1:0]        ctrl_start,
  input  logic              size_we,
  input  logic [SIZE_W-1:0] size_wdata,
  input  logic              wf_empty,
  input  logic              rf_full,
  input  logic              port_busy,
  input  logic              port_rvalid,
  output logic              wr_active,
  output logic              rd_active,
  output logic [SIZE_W-1:0] size_q,
  output logic              port_wvalid,
  output logic              port_rready,
  output logic              wf_pop,
  output logic              rf_push
);
  logic idle, go_wr, go_rd;

  assign idle  = !wr_active && !rd_active;
  assign go_wr = ctrl_we && idle && ctrl_start[0];
  assign go_rd = ctrl_we && idle && ctrl_start[1] && !ctrl_start[0];

  assign port_wvalid = wr_active && !wf_empty;
  assign wf_pop      = port_wvalid && !port_busy;
  assign port_rready = rd_active && (size_q != '0) && !rf_full;
  assign rf_push     = port_rready && port_rvalid;

  always_ff @(posedge clk) begin
    if (rst)                        wr_active <= 1'b0;
    else if (wr_active && wf_empty) wr_active <= 1'b0;
    else if (go_wr)                 wr_active <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                             rd_active <= 1'b0;
    else if (rd_active && size_q == '0)  rd_active <= 1'b0;
    else if (go_rd)                      rd_active <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                         size_q <= '0;
    else if (rf_push)                size_q <= size_q - SIZE_W'(1);
    else if (size_we && !rd_active)  size_q <= size_wdata;
  end

  AST_ONE_XFER: assert property (@(posedge clk) disable iff (rst)
    !(wr_active && rd_active)); // R10

  AST_WR_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    (wr_active && wf_empty) |=> !wr_active); // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_active && ctrl_we) |=> !rd_active); // R10

  AST_SIZE_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    rf_push |=> size_q == $past(size_q) - SIZE_W'(1)); // R6
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cpb_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int WF_DEPTH = 1024,
  parameter int RF_DEPTH = 256,
  parameter int SIZE_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              port_wvalid,
  output logic [DATA_W-1:0] port_wdata,
  input  logic              port_busy,
  input  logic              port_rvalid,
  input  logic [DATA_W-1:0] port_rdata,
  output logic              port_rready,
  input  logic              port_abort_n,
  input  logic              port_rip,
  input  logic              port_dalign,
  input  logic              port_cfgerr
);
  localparam int WCW = $clog2(WF_DEPTH + 1);
  localparam int RCW = $clog2(RF_DEPTH + 1);

  logic              ctrl_we, sw_rst, int_rst, flush;
  logic              wf_push, rf_pop, size_we;
  logic              wf_pop, rf_push, wf_empty, rf_full;
  logic              wr_active, rd_active;
  logic [SIZE_W-1:0] size_q;
  logic [WCW-1:0]    wf_count;
  logic [RCW-1:0]    rf_count;
  logic [DATA_W-1:0] rf_head, rd_mux;
  logic [STAT_W-1:0] stat;

  assign ctrl_we  = bus_wr_en && (bus_addr == A_CTRL);
  assign sw_rst   = ctrl_we && bus_wdata[CTL_SOFT];
  assign int_rst  = rst || sw_rst;
  assign flush    = ctrl_we && bus_wdata[CTL_FLUSH];
  assign wf_push  = bus_wr_en && (bus_addr == A_WDATA);
  assign size_we  = bus_wr_en && (bus_addr == A_SIZE);
  assign rf_pop   = bus_rd_en && (bus_addr == A_RDATA);
  assign wf_empty = (wf_count == '0);
  assign rf_full  = (rf_count == RCW'(RF_DEPTH));

  cpb_fifo #(.DW(DATA_W), .DEPTH(WF_DEPTH)) u_wfifo (
    .clk(clk), .rst(int_rst), .clr(flush),
    .push(wf_push), .wdata(bus_wdata),
    .pop(wf_pop), .rdata(port_wdata), .count(wf_count)
  );

  cpb_fifo #(.DW(DATA_W), .DEPTH(RF_DEPTH)) u_rfifo (
    .clk(clk), .rst(int_rst), .clr(flush),
    .push(rf_push), .wdata(port_rdata),
    .pop(rf_pop), .rdata(rf_head), .count(rf_count)
  );

  cpb_xfer_engine #(.SIZE_W(SIZE_W)) u_engine (
    .clk(clk), .rst(int_rst),
    .ctrl_we(ctrl_we), .ctrl_start({bus_wdata[CTL_GO_RD], bus_wdata[CTL_GO_WR]}),
    .size_we(size_we), .size_wdata(bus_wdata[SIZE_W-1:0]),
    .wf_empty(wf_empty), .rf_full(rf_full),
    .port_busy(port_busy), .port_rvalid(port_rvalid),
    .wr_active(wr_active), .rd_active(rd_active), .size_q(size_q),
    .port_wvalid(port_wvalid), .port_rready(port_rready),
    .wf_pop(wf_pop), .rf_push(rf_push)
  );

  assign stat = {port_cfgerr, port_dalign, port_rip, port_abort_n,
                 STAT_ONES, !(wr_active || rd_active)};

  always_comb begin
    case (bus_addr)
      A_CTRL:  rd_mux = DATA_W'({rd_active, wr_active});
      A_STAT:  rd_mux = DATA_W'(stat);
      A_SIZE:  rd_mux = DATA_W'(size_q);
      A_RDATA: rd_mux = rf_head;
      A_WVAC:  rd_mux = DATA_W'(WCW'(WF_DEPTH) - wf_count);
      A_ROCC:  rd_mux = DATA_W'(rf_count);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (port_wvalid && port_busy && !flush && !sw_rst)
      |=> (port_wvalid && $stable(port_wdata))); // R4

  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (wf_count == '0 && rf_count == '0 && size_q == '0
                && !wr_active && !rd_active)); // R12

  AST_RREADY_ROOM: assert property (@(posedge clk) disable iff (rst)
    port_rready |-> (rf_count < RCW'(RF_DEPTH))); // R7
endmodule

// File: tb/cfg_port_bridge_bench.sv
module cfg_port_bridge_bench;
  localparam int WD = 1024;
  localparam int RD = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1, bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        port_wvalid, port_rready;
  logic [31:0] port_wdata;
  logic        port_busy = 1'b0, port_rvalid = 1'b0;
  logic [31:0] port_rdata = '0;
  logic        port_abort_n = 1'b1, port_rip = 1'b0, port_dalign = 1'b0, port_cfgerr = 1'b0;

  cfg_port_bridge u_cfg_port_bridge (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .port_wvalid(port_wvalid), .port_wdata(port_wdata), .port_busy(port_busy),
    .port_rvalid(port_rvalid), .port_rdata(port_rdata), .port_rready(port_rready),
    .port_abort_n(port_abort_n), .port_rip(port_rip), .port_dalign(port_dalign),
    .port_cfgerr(port_cfgerr)
  );

  int    checks = 0, failures = 0;
  string tag = "R1";
  logic [31:0] wq[$];
  logic [31:0] rq[$];
  bit    wact = 0, ract = 0, exp_chk = 0;
  int    msize = 0, busy_pct = 0, rv_pct = 0;
  logic [31:0] exp_rd = '0;

  task automatic check(input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
    end
  endtask

  // Behavioural reference: applied once per rising edge from the pre-edge state.
  task automatic model_step();
    bit wfire, rfire, rpop, wpush, ctl, idle;
    int wn, rn, sz0;
    if (rst) begin
      wq.delete(); rq.delete(); wact = 0; ract = 0; msize = 0; exp_chk = 0;
      return;
    end
    wn = wq.size(); rn = rq.size(); sz0 = msize; idle = !wact && !ract;
    exp_chk = 0;
    if (bus_rd_en) begin
      exp_chk = 1;
      case (bus_addr)
        3'd0: exp_rd = {30'd0, ract, wact};
        3'd1: exp_rd = {23'd0, port_cfgerr, port_dalign, port_rip, port_abort_n, 4'hF, idle};
        3'd2: exp_rd = 32'(msize);
        3'd4: if (rn > 0) exp_rd = rq[0]; else exp_chk = 0;
        3'd5: exp_rd = 32'(WD - wn);
        3'd6: exp_rd = 32'(rn);
        default: exp_rd = '0;
      endcase
    end
    ctl = bus_wr_en && bus_addr == 3'd0;
    if (ctl && bus_wdata[3]) begin
      wq.delete(); rq.delete(); wact = 0; ract = 0; msize = 0;
      return;
    end
    wfire = wact && wn > 0 && !port_busy;
    rfire = ract && msize != 0 && rn < RD && port_rvalid;
    rpop  = bus_rd_en && bus_addr == 3'd4 && rn > 0;
    wpush = bus_wr_en && bus_addr == 3'd3 && wn < WD;
    if (wfire) void'(wq.pop_front());
    if (wpush) wq.push_back(bus_wdata);
    if (rpop) void'(rq.pop_front());
    if (rfire) begin
      rq.push_back(port_rdata);
      msize--;
    end else if (bus_wr_en && bus_addr == 3'd2 && !ract) begin
      msize = int'(bus_wdata[11:0]);
    end
    if (wact && wn == 0) wact = 0;
    if (ract && sz0 == 0) ract = 0;
    if (ctl && bus_wdata[2]) begin
      wq.delete(); rq.delete();
    end
    if (ctl && idle) begin
      if (bus_wdata[0]) wact = 1;
      else if (bus_wdata[1]) ract = 1;
    end
  endtask

  task automatic cyc();
    bit wv, rr;
    @(posedge clk);
    model_step();
    @(negedge clk);
    wv = wact && wq.size() > 0;
    rr = ract && msize != 0 && rq.size() < RD;
    check("R4", "port_wvalid", 32'(port_wvalid), 32'(wv));
    if (wv) check("R4", "port_wdata", port_wdata, wq[0]);
    check("R7", "port_rready", 32'(port_rready), 32'(rr));
    if (exp_chk) check(tag, "bus_rdata", bus_rdata, exp_rd);
    port_busy   = ($urandom_range(99) < busy_pct);
    port_rvalid = ($urandom_range(99) < rv_pct);
    port_rdata  = $urandom();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a);
    bus_rd_en = 1'b1; bus_addr = a;
    cyc();
    bus_rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && (wact || ract); i++) cyc();
  endtask

  task automatic read_all();
    for (int a = 0; a < 8; a++) if (a != 4) rd(3'(a));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    cyc();

    tag = "R1";                       // reset values and map
    read_all();
    check("R1", "rdata_hold", bus_rdata, 32'(0));

    tag = "R2";                       // status layout
    rd(3'd1);
    check("R2", "status_idle", bus_rdata, 32'h3F);
    tag = "R9";
    port_cfgerr = 1; port_rip = 1; port_abort_n = 0; cyc(); rd(3'd1);
    port_dalign = 1; port_rip = 0; cyc(); rd(3'd1);
    port_cfgerr = 0; port_dalign = 0; port_abort_n = 1; cyc(); rd(3'd1);

    tag = "R3";                       // fill a few words
    for (int i = 0; i < 5; i++) wr(3'd3, 32'hA000_0000 + 32'(i));
    rd(3'd5);
    check("R3", "vacancy_5", bus_rdata, 32'd1019);

    tag = "R4";                       // outbound with back-pressure
    busy_pct = 40;
    wr(3'd0, 32'h1);
    rd(3'd1);
    tag = "R5";
    for (int i = 0; i < 3; i++) wr(3'd3, 32'hB000_0000 + 32'(i));
    wait_idle();
    cyc();
    rd(3'd0);
    check("R5", "ctrl_after_write", bus_rdata, 32'd0);
    rd(3'd1);

    tag = "R10";                      // starts ignored while busy
    busy_pct = 100;
    wr(3'd3, 32'hC0C0_0001);
    wr(3'd0, 32'h1);
    wr(3'd0, 32'h2);
    rd(3'd0);
    busy_pct = 0;
    wait_idle();
    cyc();
    rv_pct = 0;
    wr(3'd2, 32'd4);
    wr(3'd0, 32'h2);
    wr(3'd2, 32'd100);
    rd(3'd2);
    check("R10", "size_locked", bus_rdata, 32'd4);
    rv_pct = 100;
    wait_idle();
    cyc();
    wr(3'd0, 32'h3);
    rd(3'd0);
    check("R10", "both_bits_write_wins", bus_rdata, 32'd1);
    wait_idle();
    tag = "R8";
    for (int i = 0; i < 4; i++) rd(3'd4);

    tag = "R6";                       // readback with gaps, size truncation
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2);
    check("R6", "size_max", bus_rdata, 32'hFFF);
    wr(3'd2, 32'd10);
    rv_pct = 50;
    wr(3'd0, 32'h2);
    for (int i = 0; i < 4; i++) rd(3'd2);
    wait_idle();
    cyc();
    rd(3'd6);
    check("R6", "occupancy_10", bus_rdata, 32'd10);
    tag = "R8";
    for (int i = 0; i < 10; i++) rd(3'd4);
    rd(3'd4);
    rd(3'd6);
    check("R8", "empty_read_no_effect", bus_rdata, 32'd0);

    tag = "R7";                       // readback longer than the inbound FIFO
    rv_pct = 100;
    wr(3'd2, 32'd300);
    wr(3'd0, 32'h2);
    for (int i = 0; i < 280; i++) cyc();
    rd(3'd6);
    check("R7", "occupancy_full", bus_rdata, 32'd256);
    for (int i = 0; i < 50; i++) rd(3'd4);
    wait_idle();
    for (int i = 0; i < 260 && rq.size() > 0; i++) rd(3'd4);
    rd(3'd6);

    tag = "R3";                       // overfill outbound FIFO
    for (int i = 0; i < 1030; i++) wr(3'd3, 32'h5000_0000 + 32'(i));
    rd(3'd5);
    check("R3", "vacancy_full", bus_rdata, 32'd0);
    busy_pct = 30;
    tag = "R4";
    wr(3'd0, 32'h1);
    wait_idle();
    busy_pct = 0;
    rd(3'd5);

    tag = "R11";                      // flush during readback
    for (int i = 0; i < 6; i++) wr(3'd3, 32'h6000_0000 + 32'(i));
    rv_pct = 50;
    wr(3'd2, 32'd20);
    wr(3'd0, 32'h2);
    for (int i = 0; i < 8; i++) cyc();
    wr(3'd0, 32'h4);
    rd(3'd6);
    rd(3'd5);
    check("R11", "flush_vacancy", bus_rdata, 32'd1024);
    rd(3'd0);
    wait_idle();
    cyc();
    rd(3'd6);

    tag = "R12";                      // software reset overrides start
    rv_pct = 0;
    wr(3'd3, 32'h7777_0001);
    wr(3'd2, 32'd9);
    wr(3'd0, 32'h9);
    read_all();
    rd(3'd2);
    check("R12", "size_after_soft", bus_rdata, 32'd0);
    rd(3'd1);
    check("R12", "status_after_soft", bus_rdata, 32'h3F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule